// File: doc/BRIEF.md
# Ethernet PHY Mode Control Register

This block holds the primary mode-control word of an Ethernet physical-layer device and turns it into the control levels that the rest of the PHY uses. A management agent reaches it through a plain register port with an address, write data, a write strobe, a read strobe and registered read data. The word carries four live fields: a self-clearing soft reset, MII loopback, a manual speed choice and an auto-negotiation enable. All other bit positions are reserved.

The block resolves the effective link speed from three sources. Configuration straps are captured at reset and win over everything else. Next comes the speed reported by the negotiation engine, but only while negotiation is active. The manual speed bit is used last. Negotiation becomes active by default only when the captured straps do not fix the speed. Otherwise software must write the enable bit to 0 and then to 1, and that rising write also raises a one-cycle restart strobe. A soft reset keeps the reset bit reading 1 for a fixed number of cycles. During those cycles the straps are captured again and writes are dropped. Entering loopback at 100 Mb/s holds a data-valid output low for a programmable hold-off.

Top module: `phy_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, address 0 reads 16'h3000, which means reset=0, loopback=0, speed=1 and autoneg enable=1. `mii_loop_o`, `aux_loop_o` and `phy_rst_o` are then 0, and `data_ok_o` is 1.
- R2: The word at address `REG_ADDR` (default 0) has bit 14 = loopback, bit 13 = speed (1 = 100 Mb/s, 0 = 10 Mb/s) and bit 12 = autoneg enable. All three read back as written. Bits 11..0 always read 0. A write to any other address has no effect, and a read of any other address returns 0.
- R3: Writing 1 to bit 15 returns bits 14..12 to their R1 defaults in the cycle of that write. `phy_rst_o` is then high for exactly `RST_CYCLES` cycles, and bit 15 reads 1 for that whole time.
- R4: Any write arriving while `phy_rst_o` is high is ignored.
- R5: The straps `strap_fix_i`/`strap_spd_i` are captured while `rst_n` is low and in every busy cycle of a soft reset. If the captured fix bit is 1, `speed_o` equals the captured speed strap, whatever the register bits and negotiation state.
- R6: If the captured fix bit is 0, `speed_o` is `an_spd_i` while `an_en_o` is 1, and otherwise the speed bit. The new value appears in the cycle after the write edge, with no extra stage.
- R7: After reset, `an_en_o` equals the inverse of the captured fix strap. A write with bit 12 = 0 clears it. A write with bit 12 = 1 while the bit reads 0 sets it and pulses `an_restart_o` for one cycle. A write with bit 12 = 1 while the bit already reads 1 changes neither output.
- R8: `mii_loop_o` follows bit 14. `aux_loop_o` equals `aux_loop_i` while bit 14 is 0, and is 0 while bit 14 is 1.
- R9: A write that sets bit 14 while it reads 0, at a moment when `speed_o` is 1, drives `data_ok_o` low for `HOLD_CYCLES` cycles. A soft reset returns `data_ok_o` to 1.
- R10: `mgmt_rdata` is loaded on a clock edge only when `mgmt_rd` is high, using the register contents from before that edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_addr | input | ADDR_W | Register address |
| mgmt_wdata | input | DATA_W | Write data |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_rdata | output | DATA_W | Registered read data |
| strap_fix_i | input | 1 | Strap: speed fixed by pins |
| strap_spd_i | input | 1 | Strap: fixed speed (1 = 100 Mb/s) |
| an_spd_i | input | 1 | Speed resolved by the negotiation engine |
| aux_loop_i | input | 2 | Loopback controls from the secondary loopback register |
| speed_o | output | 1 | Effective link speed (1 = 100 Mb/s) |
| an_en_o | output | 1 | Negotiation active |
| an_restart_o | output | 1 | One-cycle negotiation restart strobe |
| mii_loop_o | output | 1 | MII loopback enable |
| aux_loop_o | output | 2 | Secondary loopback controls after masking |
| data_ok_o | output | 1 | Data valid, low during the loopback hold-off |
| phy_rst_o | output | 1 | Soft-reset level to the rest of the PHY |

## Verification
The bench targets three errors: a rewrite of an already-set enable bit that wrongly starts negotiation, a negotiation state that survives a strap recapture, and a design that leaves the reset bit reading 0 during the busy window. Each of these shows up as a wrong `an_en_o`, `an_restart_o` or bit-15 readback. It writes during the busy window and then reads back, so that a design accepting those writes shows a loopback bit or a speed that should have been dropped. It changes the straps during a soft reset to confirm that the new fixed speed overrides both the speed bit and the negotiated speed. It enters loopback at 100 Mb/s and again at 10 Mb/s, so that a hold-off of the wrong length, or one started at the wrong speed, shows up on `data_ok_o`.

// File: rtl/phy_bmcr_pkg.sv
// Package: field positions and default contents of the PHY mode-control word.
// Assumes a 16-bit management data word.
package phy_bmcr_pkg;
    localparam int BIT_RST  = 15;
    localparam int BIT_LOOP = 14;
    localparam int BIT_SPD  = 13;
    localparam int BIT_ANEN = 12;

    typedef struct packed {
        logic loop;
        logic spd;
        logic an;
    } ctl_bits_t;

    localparam ctl_bits_t CTL_DEFAULT = '{loop: 1'b0, spd: 1'b1, an: 1'b1};
endpackage

// File: rtl/bmcr_rst_seq.sv
// Soft-reset sequencer. A start pulse makes busy_o high for RST_CYCLES cycles.
// The straps are captured while rst_n is low and in every busy cycle.
// Assumes RST_CYCLES >= 1 and that start_i is never raised while busy.
module bmcr_rst_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fix_pin_i,
    input  logic spd_pin_i,
    output logic busy_o,
    output logic fix_q_o,
    output logic spd_q_o
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    // Busy window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= CW'(RST_CYCLES - 1);
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Strap capture during any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_o) begin
            fix_q_o <= fix_pin_i;
            spd_q_o <= spd_pin_i;
        end
    end
endmodule

// File: rtl/bmcr_ctl.sv
// Control-bit storage and the edge-qualified negotiation enable.
// wr_i is an accepted write, already qualified by address and not-busy.
// While busy_i is high the bits stay at their defaults, and the active
// negotiation state follows the strap pin.
module bmcr_ctl
    import phy_bmcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  logic      wr_rst_i,
    input  ctl_bits_t wr_bits_i,
    input  logic      busy_i,
    input  logic      fix_pin_i,
    output ctl_bits_t ctl_o,
    output logic      an_act_o,
    output logic      restart_o
);
    // Register bits, negotiation state and restart strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o     <= CTL_DEFAULT;
            an_act_o  <= !fix_pin_i;
            restart_o <= 1'b0;
        end else begin
            restart_o <= 1'b0;
            if (busy_i) begin
                ctl_o    <= CTL_DEFAULT;
                an_act_o <= !fix_pin_i;
            end else if (wr_i) begin
                if (wr_rst_i) begin
                    ctl_o <= CTL_DEFAULT;
                end else begin
                    ctl_o <= wr_bits_i;
                    if (!wr_bits_i.an) begin
                        an_act_o <= 1'b0;
                    end else if (!ctl_o.an) begin
                        an_act_o  <= 1'b1;
                        restart_o <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bmcr_holdoff.sv
// Loopback hold-off timer. A load starts a window of HOLD_CYCLES cycles in
// which ok_o is low. clr_i ends the window at once. Assumes HOLD_CYCLES >= 1.
module bmcr_holdoff #(
    parameter int HOLD_CYCLES = 137500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic load_i,
    output logic ok_o
);
    localparam int W = $clog2(HOLD_CYCLES + 1);

    logic [W-1:0] cnt_q;

    // Hold-off countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_q <= '0;
        else if (load_i)      cnt_q <= W'(HOLD_CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/phy_mode_ctrl.sv
// Top of the PHY mode-control register. It decodes management accesses,
// resolves the effective speed and loopback controls, and registers read data.
// Assumes DATA_W >= 16 and that the negotiation engine provides an_spd_i.
module phy_mode_ctrl
    import phy_bmcr_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int REG_ADDR    = 0,
    parameter int RST_CYCLES  = 16,
    parameter int HOLD_CYCLES = 137500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              strap_fix_i,
    input  logic              strap_spd_i,
    input  logic              an_spd_i,
    input  logic [1:0]        aux_loop_i,
    output logic              speed_o,
    output logic              an_en_o,
    output logic              an_restart_o,
    output logic              mii_loop_o,
    output logic [1:0]        aux_loop_o,
    output logic              data_ok_o,
    output logic              phy_rst_o
);
    logic        hit, wr_ok, busy, fix_q, spd_q, an_act, ho_load;
    ctl_bits_t   ctl, wr_bits;
    logic [DATA_W-1:0] rd_word;

    assign hit     = (mgmt_addr == ADDR_W'(REG_ADDR));
    assign wr_ok   = mgmt_wr && hit && !busy;
    assign wr_bits = '{loop: mgmt_wdata[BIT_LOOP], spd: mgmt_wdata[BIT_SPD],
                       an: mgmt_wdata[BIT_ANEN]};

    bmcr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n),
        .start_i(wr_ok && mgmt_wdata[BIT_RST]),
        .fix_pin_i(strap_fix_i), .spd_pin_i(strap_spd_i),
        .busy_o(busy), .fix_q_o(fix_q), .spd_q_o(spd_q)
    );

    bmcr_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ok),
        .wr_rst_i(mgmt_wdata[BIT_RST]), .wr_bits_i(wr_bits),
        .busy_i(busy), .fix_pin_i(strap_fix_i),
        .ctl_o(ctl), .an_act_o(an_act), .restart_o(an_restart_o)
    );

    // Hold-off starts on a loopback entry made while running at 100 Mb/s.
    assign ho_load = wr_ok && !mgmt_wdata[BIT_RST] && wr_bits.loop && !ctl.loop && speed_o;

    bmcr_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr_i(busy), .load_i(ho_load), .ok_o(data_ok_o)
    );

    // Speed priority: straps, then negotiation, then the manual bit.
    always_comb begin
        if (fix_q)       speed_o = spd_q;
        else if (an_act) speed_o = an_spd_i;
        else             speed_o = ctl.spd;
    end

    assign an_en_o    = an_act;
    assign mii_loop_o = ctl.loop;
    assign aux_loop_o = ctl.loop ? 2'b00 : aux_loop_i;
    assign phy_rst_o  = busy;

    // Read word assembly; reserved bits read as zero.
    always_comb begin
        rd_word           = '0;
        rd_word[BIT_RST]  = busy;
        rd_word[BIT_LOOP] = ctl.loop;
        rd_word[BIT_SPD]  = ctl.spd;
        rd_word[BIT_ANEN] = ctl.an;
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mgmt_rdata <= '0;
        else if (mgmt_rd) mgmt_rdata <= hit ? rd_word : '0;
    end
endmodule

// File: rtl/bmcr_chk.sv
// Checker for phy_mode_ctrl, attached with bind. It observes ports only.
module bmcr_chk #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int REG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic [DATA_W-1:0] mgmt_wdata,
    input logic              mgmt_wr,
    input logic              mgmt_rd,
    input logic [DATA_W-1:0] mgmt_rdata,
    input logic              an_restart_o,
    input logic              mii_loop_o,
    input logic [1:0]        aux_loop_o,
    input logic              phy_rst_o
);
    a_r7_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |=> !an_restart_o);

    a_r7_restart_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |-> $past(mgmt_wr && mgmt_addr == ADDR_W'(REG_ADDR) && mgmt_wdata[12]));

    a_r8_aux_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mii_loop_o |-> (aux_loop_o == 2'b00));

    a_r3_busy_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_o |-> !mii_loop_o);

    a_r3_busy_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && mgmt_addr == ADDR_W'(REG_ADDR) && phy_rst_o) |=> mgmt_rdata[15]);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rdata[11:0] == 12'h000);

    a_r3_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_o) |-> $past(mgmt_wr && mgmt_addr == ADDR_W'(REG_ADDR) && mgmt_wdata[15]));
endmodule

bind phy_mode_ctrl bmcr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_rdata(mgmt_rdata),
    .an_restart_o(an_restart_o), .mii_loop_o(mii_loop_o),
    .aux_loop_o(aux_loop_o), .phy_rst_o(phy_rst_o)
);

// File: tb/phy_mode_ctrl_tb.sv
// Bench: a behavioural reference model is stepped on every clock edge and
// compared with all outputs 1 ns later. Directed checks are added on top.
module phy_mode_ctrl_tb;
    localparam int RST = 6;
    localparam int HOLD = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic wr = 1'b0, rd = 1'b0, fix = 1'b0, sspd = 1'b0, an_spd = 1'b0;
    logic [1:0] aux = 2'b00, aux_o;
    logic speed, an_en, restart, mloop, data_ok, prst;

    int errors = 0, checks = 0;
    bit done = 0;

    // Reference model state.
    bit m_lb = 0, m_spd = 1, m_an = 1, m_act = 1, m_fix = 0, m_sspd = 0, m_rs = 0;
    int m_busy = 0, m_hold = 0;
    logic [15:0] m_rdata = '0;

    always #2 clk = ~clk;

    phy_mode_ctrl #(.RST_CYCLES(RST), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(addr), .mgmt_wdata(wdata),
        .mgmt_wr(wr), .mgmt_rd(rd), .mgmt_rdata(rdata),
        .strap_fix_i(fix), .strap_spd_i(sspd), .an_spd_i(an_spd), .aux_loop_i(aux),
        .speed_o(speed), .an_en_o(an_en), .an_restart_o(restart),
        .mii_loop_o(mloop), .aux_loop_o(aux_o), .data_ok_o(data_ok), .phy_rst_o(prst)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_speed();
        return m_fix ? m_sspd : (m_act ? an_spd : m_spd);
    endfunction

    task automatic model_step();
        bit busy, acc;
        busy = (m_busy > 0);
        acc = wr && addr == 5'd0 && !busy;
        if (rd) m_rdata = (addr == 5'd0) ? {busy, m_lb, m_spd, m_an, 12'h000} : 16'h0;
        m_rs = 0;
        if (busy) begin
            m_hold = 0;
        end else if (acc && !wdata[15] && wdata[14] && !m_lb && m_speed()) begin
            m_hold = HOLD;
        end else if (m_hold > 0) begin
            m_hold--;
        end
        if (busy) begin
            m_lb = 0; m_spd = 1; m_an = 1; m_act = !fix;
            m_fix = fix; m_sspd = sspd;
            m_busy--;
        end else if (acc) begin
            if (wdata[15]) begin
                m_lb = 0; m_spd = 1; m_an = 1; m_busy = RST;
            end else begin
                if (!wdata[12]) m_act = 0;
                else if (!m_an) begin m_act = 1; m_rs = 1; end
                m_lb = wdata[14]; m_spd = wdata[13]; m_an = wdata[12];
            end
        end
    endtask

    // Lock-step comparison against the reference model.
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_lb = 0; m_spd = 1; m_an = 1; m_act = !fix; m_fix = fix; m_sspd = sspd;
                m_rs = 0; m_busy = 0; m_hold = 0; m_rdata = '0;
            end else begin
                model_step();
            end
            #1;
            if (rst_n && !done) begin
                chk("R2/R10 rdata", rdata, m_rdata);
                chk("R3 phy_rst", 16'(prst), 16'(m_busy > 0));
                chk(m_fix ? "R5 speed" : "R6 speed", 16'(speed), 16'(m_speed()));
                chk("R7 an_en", 16'(an_en), 16'(m_act));
                chk("R7 restart", 16'(restart), 16'(m_rs));
                chk("R8 mii_loop", 16'(mloop), 16'(m_lb));
                chk("R8 aux_loop", 16'(aux_o), 16'(m_lb ? 2'b00 : aux));
                chk("R9 data_ok", 16'(data_ok), 16'(m_hold == 0));
            end
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0; addr = '0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input string tag, input logic [15:0] exp);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; addr = '0;
        chk(tag, rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        rd_reg(5'd0, "R1 reset word", 16'h3000);
        chk("R1 loop/rst", {14'h0, mloop, prst}, 16'h0);
        chk("R1 data_ok", 16'(data_ok), 16'h1);
        // R6: manual speed with negotiation off.
        wr_reg(5'd0, 16'h0000);
        @(negedge clk); chk("R6 speed 10", 16'(speed), 16'h0);
        wr_reg(5'd0, 16'h2000);
        @(negedge clk); chk("R6 speed 100", 16'(speed), 16'h1);
        // R7: rising enable write; then rewrite of an already-set bit.
        wr_reg(5'd0, 16'h1000);
        an_spd = 1'b0;
        @(negedge clk); chk("R6 negotiated speed", 16'(speed), 16'h0);
        wr_reg(5'd0, 16'h1000);
        // R8: auxiliary loopback pass-through and masking.
        aux = 2'b10;
        wr_reg(5'd0, 16'h2000);
        @(negedge clk); chk("R8 aux pass", 16'(aux_o), 16'h2);
        // R9: loopback entry at 100 Mb/s.
        wr_reg(5'd0, 16'h6000);
        chk("R9 hold low", 16'(data_ok), 16'h0);
        repeat (HOLD + 3) @(negedge clk);
        chk("R9 hold end", 16'(data_ok), 16'h1);
        // R9: entry at 10 Mb/s starts no hold-off.
        wr_reg(5'd0, 16'h0000);
        wr_reg(5'd0, 16'h4000);
        chk("R9 no hold at 10", 16'(data_ok), 16'h1);
        // R2: other addresses and reserved bits.
        wr_reg(5'd3, 16'h2000);
        rd_reg(5'd0, "R2 other addr ignored", 16'h4000);
        rd_reg(5'd5, "R2 other addr reads 0", 16'h0000);
        wr_reg(5'd0, 16'h2FFF);
        rd_reg(5'd0, "R2 reserved read 0", 16'h2000);
        // R3/R4/R5: soft reset, writes dropped, straps recaptured.
        wr_reg(5'd0, 16'h6000);
        wr_reg(5'd0, 16'h8000);
        fix = 1'b1; sspd = 1'b0;
        rd_reg(5'd0, "R3 busy readback", 16'hB000);
        wr_reg(5'd0, 16'h4000);
        repeat (RST + 2) @(negedge clk);
        chk("R3 busy over", 16'(prst), 16'h0);
        rd_reg(5'd0, "R4 busy write ignored", 16'h3000);
        an_spd = 1'b1;
        @(negedge clk);
        chk("R5 strap speed", 16'(speed), 16'h0);
        chk("R7 inactive after fixed strap", 16'(an_en), 16'h0);
        wr_reg(5'd0, 16'h3000);
        chk("R7 set-on-set no effect", 16'(an_en), 16'h0);
        wr_reg(5'd0, 16'h2000);
        @(negedge clk); addr = 5'd0; wdata = 16'h1000; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        chk("R7 restart pulse", 16'(restart), 16'h1);
        chk("R7 enabled after clear-set", 16'(an_en), 16'h1);
        @(negedge clk); chk("R7 restart single", 16'(restart), 16'h0);
        chk("R5 strap over negotiation", 16'(speed), 16'h0);
        // R5: power-up reset with a 100 Mb/s strap.
        sspd = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R5 strap at reset", 16'(speed), 16'h1);
        chk("R7 off at reset", 16'(an_en), 16'h0);
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        wr_reg(5'd0, 16'h0000);
        chk("R10 rdata held", rdata, 16'h3000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule